// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a final page descriptor. It does this by walking a three-level tree of 32-bit descriptors held in memory: a top table, a middle table and a leaf table. A walk starts from one of two base pointers. The supervisor base is used for privileged accesses and the user base for all others. Each table descriptor that is read must be valid before the walk goes on. A leaf entry may point once, indirectly, to the real page descriptor. The write-protect flags of every level are ORed together as the walk proceeds.

While it walks, the block keeps the tree's bookkeeping flags current. It sets the used flag on every descriptor it passes. It sets the modified flag on the page descriptor when a write is legal. A write-back happens only when a flag actually changes. When the walk ends, the block returns the page descriptor with the merged write-protect flag and a fault vector, and pulses a done strobe. A walk request is a valid/ready handshake. The request inputs are sampled on the accepting edge, and `walk_ready` is high only while no walk is running. The memory request port is also valid/ready. The block holds `mem_req_valid`, the address, the write flag and the data stable until `mem_req_ready` is seen. It keeps one access outstanding and waits for a one-cycle `mem_rsp_valid` before it issues the next access. The response path has no back-pressure.

Descriptor flags: bit 0 resident (page), bit 1 valid (table), bit 2 write-protect, bit 3 used, bit 4 modified, bit 7 supervisor-only. Fault vector bits: 0 write-protect, 1 supervisor, 2 page fault, 3 indirect loop, 4 middle-level invalid, 5 top-level invalid, 6 bus error.

Top module: `ptw_walker`

## Requirements
- R1: `walk_ready` is high only when idle. An accepted request makes `busy` high on the next cycle. `done` is high for exactly one cycle per walk, and the block is then idle again. After reset, `busy`=0, `done`=0 and `walk_ready`=1.
- R2: The top-table base is `super_root` when `walk_super`=1 and `user_root` otherwise. The top entry is at {base[31:9], va[31:25], 2'b00}. The middle entry is at {topdesc[31:9], va[24:18], 2'b00}.
- R3: The leaf entry is at {middesc[31:8], va[17:12], 2'b00} when `walk_big_page`=0. It is at {middesc[31:7], va[17:13], 2'b00} when `walk_big_page`=1.
- R4: A top or middle descriptor with bit 1 clear ends the walk with fault bit 5 (top) or bit 4 (middle) set and a zero descriptor. No further access is made.
- R5: A valid top or middle descriptor with its used bit (bit 3) clear is written back to the same address with bit 3 set. If bit 3 is already set, nothing is written.
- R6: A leaf entry whose bits [1:0] are 2'b10 is indirect. The real descriptor is read from {entry[31:2], 2'b00}, and any write-back goes to that address. If the second descriptor is also indirect, the walk ends with fault bit 3 and a zero descriptor.
- R7: A final descriptor with bit 0 clear ends the walk with fault bit 2 and a zero descriptor.
- R8: The returned descriptor has bit 2 set when any level along the walk had bit 2 set.
- R9: A write that is neither write-protected (at any level) nor a user access to a supervisor-only page sets bits 3 and 4 of the page descriptor. Every other successful lookup sets bit 3 only. The descriptor is written back only if this changes it. The returned descriptor carries the updated flags.
- R10: A user access to a page with bit 7 set raises fault bit 1. Otherwise, a write with the merged write-protect flag set raises fault bit 0. At most one fault bit is ever set.
- R11: An error response to any table read ends the walk with fault bit 6 only and a zero descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| walk_valid | input | 1 | Walk request valid |
| walk_ready | output | 1 | Block can accept a walk |
| walk_vaddr | input | 32 | Virtual address to translate |
| walk_super | input | 1 | Access is privileged |
| walk_write | input | 1 | Access is a write |
| walk_big_page | input | 1 | 1 selects 8 KiB pages, 0 selects 4 KiB |
| user_root | input | 32 | Top-table base for user accesses |
| super_root | input | 32 | Top-table base for privileged accesses |
| mem_req_valid | output | 1 | Memory access request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | Access is a write-back |
| mem_req_addr | output | 32 | Byte address of the descriptor |
| mem_req_wdata | output | 32 | Write-back data |
| mem_rsp_valid | input | 1 | Response or write acknowledge |
| mem_rsp_rdata | input | 32 | Read data |
| mem_rsp_err | input | 1 | Read ended in a bus error |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk strobe |
| walk_desc | output | 32 | Final descriptor with merged write-protect |
| walk_fault | output | 7 | Fault vector |

## Verification
The bench targets the 8 KiB leaf index by placing a valid entry only where the 8 KiB formula points and a zero where the 4 KiB formula points. A walker that mixed up the two shifts would return a page fault instead of the page. It then repeats walks whose flags are already set and counts the memory writes. A walker that wrote back unconditionally would show writes where none are expected. It also tests write-protect set only at the middle level, and a supervisor page that is also write-protected. These catch walkers that fail to merge protection across levels, that set the modified bit on an illegal write, or that report both faults at once. Finally it covers single and double indirection and a bus error on the middle read. These expose a walker that follows a loop, writes the used flag to the wrong address, or keeps walking after an error.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned DW = 32;

  // descriptor flag positions
  localparam int unsigned B_RES  = 0;
  localparam int unsigned B_TVAL = 1;
  localparam int unsigned B_WP   = 2;
  localparam int unsigned B_USED = 3;
  localparam int unsigned B_MOD  = 4;
  localparam int unsigned B_SUP  = 7;

  // fault vector positions
  localparam int unsigned F_WP   = 0;
  localparam int unsigned F_SP   = 1;
  localparam int unsigned F_PF   = 2;
  localparam int unsigned F_IL   = 3;
  localparam int unsigned F_PTB  = 4;
  localparam int unsigned F_PTA  = 5;
  localparam int unsigned F_BERR = 6;
  localparam int unsigned FW     = 7;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_TOP, S_WB_TOP, S_RD_MID, S_WB_MID, S_RD_LEAF, S_RD_IND, S_WB_LEAF
  } walk_st_e;
endpackage

// File: rtl/ptw_addr_calc.sv
module ptw_addr_calc
  import ptw_pkg::*;
(
  input  logic [31:12]  vpn,
  input  logic [31:9]   root_base,
  input  logic [DW-1:0] tbl_desc,
  input  logic          big_page,
  output logic [DW-1:0] top_addr,
  output logic [DW-1:0] mid_addr,
  output logic [DW-1:0] leaf_addr
);
  logic unused_low;
  assign unused_low = ^{tbl_desc[6:0], vpn[12]};

  assign top_addr = {root_base, vpn[31:25], 2'b00};
  assign mid_addr = {tbl_desc[31:9], vpn[24:18], 2'b00};

  always_comb begin
    if (big_page) leaf_addr = {tbl_desc[31:7], vpn[17:13], 2'b00};
    else          leaf_addr = {tbl_desc[31:8], vpn[17:12], 2'b00};
  end
endmodule

// File: rtl/ptw_page_eval.sv
module ptw_page_eval
  import ptw_pkg::*;
(
  input  logic [DW-1:0] desc,
  input  logic          wp_upper,
  input  logic          is_super,
  input  logic          is_write,
  output logic [DW-1:0] wb_desc,
  output logic          wb_needed,
  output logic [DW-1:0] res_desc,
  output logic [FW-1:0] flt
);
  logic resident, wp_all, sup_viol, legal_wr;

  always_comb begin
    resident = desc[B_RES];
    wp_all   = wp_upper | desc[B_WP];
    sup_viol = !is_super && desc[B_SUP];
    legal_wr = is_write && !wp_all && !sup_viol;

    wb_desc          = desc;
    wb_desc[B_USED]  = 1'b1;
    wb_desc[B_MOD]   = desc[B_MOD] | legal_wr;
    wb_needed        = resident && (wb_desc != desc);

    res_desc         = wb_desc;
    res_desc[B_WP]   = wp_all;
    if (!resident) res_desc = '0;

    flt        = '0;
    flt[F_PF]  = !resident;
    flt[F_SP]  = resident && sup_viol;
    flt[F_WP]  = resident && !sup_viol && is_write && wp_all;
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          walk_valid,
  output logic          walk_ready,
  input  logic [31:0]   walk_vaddr,
  input  logic          walk_super,
  input  logic          walk_write,
  input  logic          walk_big_page,
  input  logic [31:0]   user_root,
  input  logic [31:0]   super_root,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [31:0]   mem_req_addr,
  output logic [31:0]   mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_rdata,
  input  logic          mem_rsp_err,
  output logic          busy,
  output logic          done,
  output logic [31:0]   walk_desc,
  output logic [6:0]    walk_fault
);
  walk_st_e        state;
  logic            issued;
  logic [31:12]    vpn;
  logic [31:9]     root_base;
  logic            is_sup, is_wr, big;
  logic            wp_acc;
  logic [DW-1:0]   cur_desc, cur_addr;
  logic [DW-1:0]   top_addr, mid_addr, leaf_addr;
  logic [DW-1:0]   ev_wb, ev_res;
  logic            ev_wb_needed;
  logic [FW-1:0]   ev_flt;
  logic            rsp_fire, rd_indirect;

  logic unused_in;
  assign unused_in = ^{walk_vaddr[11:0], user_root[8:0], super_root[8:0]};

  ptw_addr_calc u_addr (
    .vpn(vpn), .root_base(root_base), .tbl_desc(cur_desc), .big_page(big),
    .top_addr(top_addr), .mid_addr(mid_addr), .leaf_addr(leaf_addr)
  );

  ptw_page_eval u_eval (
    .desc(mem_rsp_rdata), .wp_upper(wp_acc), .is_super(is_sup), .is_write(is_wr),
    .wb_desc(ev_wb), .wb_needed(ev_wb_needed), .res_desc(ev_res), .flt(ev_flt)
  );

  assign busy          = (state != S_IDLE);
  assign walk_ready    = (state == S_IDLE);
  assign mem_req_valid = busy && !issued;
  assign mem_req_write = (state == S_WB_TOP) || (state == S_WB_MID) || (state == S_WB_LEAF);
  assign mem_req_wdata = cur_desc;
  assign rsp_fire      = issued && mem_rsp_valid;
  assign rd_indirect   = (mem_rsp_rdata[1:0] == 2'b10);

  always_comb begin
    case (state)
      S_RD_TOP:  mem_req_addr = top_addr;
      S_RD_MID:  mem_req_addr = mid_addr;
      S_RD_LEAF: mem_req_addr = leaf_addr;
      default:   mem_req_addr = cur_addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      issued     <= 1'b0;
      done       <= 1'b0;
      vpn        <= '0;
      root_base  <= '0;
      is_sup     <= 1'b0;
      is_wr      <= 1'b0;
      big        <= 1'b0;
      wp_acc     <= 1'b0;
      cur_desc   <= '0;
      cur_addr   <= '0;
      walk_desc  <= '0;
      walk_fault <= '0;
    end else begin
      done <= 1'b0;
      if (mem_req_valid && mem_req_ready) issued <= 1'b1;
      if (rsp_fire) issued <= 1'b0;
      case (state)
        S_IDLE: if (walk_valid) begin
          vpn        <= walk_vaddr[31:12];
          root_base  <= walk_super ? super_root[31:9] : user_root[31:9];
          is_sup     <= walk_super;
          is_wr      <= walk_write;
          big        <= walk_big_page;
          wp_acc     <= 1'b0;
          walk_desc  <= '0;
          walk_fault <= '0;
          state      <= S_RD_TOP;
        end
        S_RD_TOP, S_RD_MID: if (rsp_fire) begin
          if (mem_rsp_err) begin
            walk_fault[F_BERR] <= 1'b1;
            done <= 1'b1; state <= S_IDLE;
          end else if (!mem_rsp_rdata[B_TVAL]) begin
            if (state == S_RD_TOP) walk_fault[F_PTA] <= 1'b1;
            else                   walk_fault[F_PTB] <= 1'b1;
            done <= 1'b1; state <= S_IDLE;
          end else begin
            wp_acc   <= wp_acc | mem_rsp_rdata[B_WP];
            cur_addr <= mem_req_addr;
            cur_desc <= mem_rsp_rdata | (DW'(1) << B_USED);
            if (!mem_rsp_rdata[B_USED])
              state <= (state == S_RD_TOP) ? S_WB_TOP : S_WB_MID;
            else
              state <= (state == S_RD_TOP) ? S_RD_MID : S_RD_LEAF;
          end
        end
        S_WB_TOP: if (rsp_fire) state <= S_RD_MID;
        S_WB_MID: if (rsp_fire) state <= S_RD_LEAF;
        S_RD_LEAF, S_RD_IND: if (rsp_fire) begin
          if (mem_rsp_err) begin
            walk_fault[F_BERR] <= 1'b1;
            done <= 1'b1; state <= S_IDLE;
          end else if (rd_indirect && state == S_RD_LEAF) begin
            cur_addr <= {mem_rsp_rdata[31:2], 2'b00};
            state    <= S_RD_IND;
          end else if (rd_indirect) begin
            walk_fault[F_IL] <= 1'b1;
            done <= 1'b1; state <= S_IDLE;
          end else begin
            if (state == S_RD_LEAF) cur_addr <= mem_req_addr;
            walk_desc  <= ev_res;
            walk_fault <= ev_flt;
            cur_desc   <= ev_wb;
            if (ev_wb_needed) state <= S_WB_LEAF;
            else begin done <= 1'b1; state <= S_IDLE; end
          end
        end
        S_WB_LEAF: if (rsp_fire) begin done <= 1'b1; state <= S_IDLE; end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1: strobe width, acceptance and request holding
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r1_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_valid && walk_ready) |=> busy);
  a_r1_done_idle: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  a_r1_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  // R4: table-level faults return zero
  a_r4_tbl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (walk_fault[F_PTA] || walk_fault[F_PTB])) |-> (walk_desc == '0));
  // R5 / R9: every write-back carries the used flag
  a_r9_wb_used: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> mem_req_wdata[B_USED]);
  // R10: at most one fault reported
  a_r10_one_fault: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot0(walk_fault));
  // R11: bus error returns a zero descriptor
  a_r11_berr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && walk_fault[F_BERR]) |-> (walk_desc == '0));
endmodule

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        walk_valid = 1'b0, walk_ready;
  logic [31:0] walk_vaddr = '0;
  logic        walk_super = 1'b0, walk_write = 1'b0, walk_big_page = 1'b0;
  logic [31:0] user_root = 32'h0000_2000, super_root = 32'h0000_1000;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;
  logic        mem_rsp_err = 1'b0;
  logic        busy, done;
  logic [31:0] walk_desc;
  logic [6:0]  walk_fault;

  always #5 clk = ~clk;

  ptw_walker dut (.*);

  int checks = 0, errors = 0, n_done = 0;
  int unsigned wr_cnt = 0;
  logic [31:0] berr_addr = 32'hFFFF_FFFF;
  logic [31:0] mem [logic [31:0]];
  logic [1:0]  stall_cnt = '0;

  typedef struct { logic [31:0] d; logic [6:0] f; int unsigned w; string tag; } exp_t;
  exp_t sb[$];

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model with periodic back-pressure
  always @(negedge clk) stall_cnt <= stall_cnt + 2'd1;
  assign mem_req_ready = (stall_cnt != 2'b11);

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    mem_rsp_err   <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      if (mem_req_write) begin
        mem[mem_req_addr] = mem_req_wdata;
        wr_cnt++;
      end else begin
        mem_rsp_rdata <= rd(mem_req_addr);
        mem_rsp_err   <= (mem_req_addr == berr_addr);
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) chk(1'b0, "R1 unexpected done", 32'h1, 32'h0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(walk_desc == e.d, {e.tag, " desc"}, walk_desc, e.d);
        chk(walk_fault == e.f, {e.tag, " fault"}, {25'd0, walk_fault}, {25'd0, e.f});
        chk(wr_cnt == e.w, {e.tag, " writes"}, wr_cnt, e.w);
      end
      n_done++;
    end
  end

  task automatic build(input logic [31:0] root, input logic [31:0] va, input bit m8,
                       input logic [31:0] td, input logic [31:0] md, input logic [31:0] ld);
    mem[{root[31:9], va[31:25], 2'b00}] = td;
    mem[{td[31:9], va[24:18], 2'b00}]   = md;
    if (m8) mem[{md[31:7], va[17:13], 2'b00}] = ld;
    else    mem[{md[31:8], va[17:12], 2'b00}] = ld;
  endtask

  task automatic walk(input logic [31:0] va, input bit sup, input bit wr, input bit m8,
                      input logic [31:0] ed, input logic [6:0] ef, input int unsigned nw,
                      input string tag);
    exp_t e;
    int prev;
    @(negedge clk);
    while (!walk_ready) @(negedge clk);
    e.d = ed; e.f = ef; e.w = wr_cnt + nw; e.tag = tag;
    sb.push_back(e);
    prev = n_done;
    walk_vaddr = va; walk_super = sup; walk_write = wr; walk_big_page = m8;
    walk_valid = 1'b1;
    @(negedge clk);
    walk_valid = 1'b0;
    chk(busy == 1'b1, "R1 busy after accept", {31'd0, busy}, 32'd1);
    wait (n_done == prev + 1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && walk_ready == 1 && mem_req_valid == 0,
        "R1 reset state", {busy, done, walk_ready, mem_req_valid}, 32'b0010);
    rst_n = 1'b1;

    // R2 R5 R9: privileged read, all flags clear
    build(32'h1000, 32'h8234_5000, 0, 32'h4002, 32'h6002, 32'h0012_3001);
    walk(32'h8234_5000, 1, 0, 0, 32'h0012_3009, 7'h00, 3, "R2/R9 super read");
    chk(rd(32'h1104) == 32'h400A, "R5 top used set", rd(32'h1104), 32'h400A);

    // R2 R9: user write sets used and modified
    build(32'h2000, 32'h8234_5000, 0, 32'h5002, 32'h7002, 32'h0044_5001);
    walk(32'h8234_5000, 0, 1, 0, 32'h0044_5019, 7'h00, 3, "R2/R9 user write");
    // R5 R9: repeat, nothing changes, no write
    walk(32'h8234_5000, 0, 1, 0, 32'h0044_5019, 7'h00, 0, "R5/R9 no redundant write");

    // R3: 8 KiB leaf index; 4 KiB slot left empty
    build(32'h1000, 32'h0000_3000, 1, 32'h8002, 32'h9002, 32'h0066_0001);
    walk(32'h0000_3000, 1, 0, 1, 32'h0066_0009, 7'h00, 3, "R3 8K index");
    // R3: 4 KiB leaf index; 8 KiB slot left empty
    build(32'h2000, 32'h0000_3000, 0, 32'hA002, 32'hB002, 32'h0077_0001);
    walk(32'h0000_3000, 0, 0, 0, 32'h0077_0009, 7'h00, 3, "R3 4K index");

    // R8 R9 R10: protection at middle level only, write
    build(32'h1000, 32'h0400_0000, 0, 32'hC002, 32'hD006, 32'h0088_0001);
    walk(32'h0400_0000, 1, 1, 0, 32'h0088_000D, 7'h01, 3, "R10 WP fault");
    chk(rd(32'hD000) == 32'h0088_0009, "R9 protected write sets used only", rd(32'hD000), 32'h0088_0009);
    walk(32'h0400_0000, 1, 0, 0, 32'h0088_000D, 7'h00, 0, "R8 read keeps merged WP");

    // R10: user write to supervisor page that is also protected
    build(32'h2000, 32'h0600_0000, 0, 32'hE002, 32'hF002, 32'h0099_0085);
    walk(32'h0600_0000, 0, 1, 0, 32'h0099_008D, 7'h02, 3, "R10 SP over WP");

    // R4: invalid top and middle descriptors
    mem[32'h1010] = 32'h0;
    walk(32'h0800_0000, 1, 0, 0, 32'h0, 7'h20, 0, "R4 top invalid");
    mem[32'h1014] = 32'h0001_0002;
    mem[32'h0001_0000] = 32'h1;
    walk(32'h0A00_0000, 1, 0, 0, 32'h0, 7'h10, 1, "R4 middle invalid");

    // R6: single indirection
    build(32'h1000, 32'h0C00_0000, 0, 32'h0001_1002, 32'h0001_2002, 32'h0001_3002);
    mem[32'h0001_3000] = 32'h00AA_0001;
    walk(32'h0C00_0000, 1, 0, 0, 32'h00AA_0009, 7'h00, 3, "R6 indirect");
    chk(rd(32'h0001_2000) == 32'h0001_3002, "R6 pointer entry untouched", rd(32'h0001_2000), 32'h0001_3002);
    chk(rd(32'h0001_3000) == 32'h00AA_0009, "R6 target gets used", rd(32'h0001_3000), 32'h00AA_0009);

    // R6: double indirection
    build(32'h1000, 32'h0E00_0000, 0, 32'h0001_4002, 32'h0001_5002, 32'h0001_6002);
    mem[32'h0001_6000] = 32'h0001_7002;
    walk(32'h0E00_0000, 1, 0, 0, 32'h0, 7'h08, 2, "R6 indirect loop");

    // R7: non-resident page
    build(32'h1000, 32'h1000_0000, 0, 32'h0001_8002, 32'h0001_9002, 32'h0000_0008);
    walk(32'h1000_0000, 1, 0, 0, 32'h0, 7'h04, 2, "R7 page fault");

    // R11: bus error on middle read
    mem[32'h1024] = 32'h0001_A002;
    berr_addr = 32'h0001_A000;
    walk(32'h1200_0000, 1, 0, 0, 32'h0, 7'h40, 1, "R11 bus error");
    berr_addr = 32'hFFFF_FFFF;

    repeat (4) @(negedge clk);
    chk(busy == 0 && walk_ready == 1, "R1 idle at end", {busy, walk_ready}, 32'b01);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule